// File: doc/BRIEF.md
# Atomic read-modify-write memory

This block is a small word-addressed shared store that several requesters reach through their own ports. Each port can issue an ordinary load or store, or one of three indivisible read-modify-write primitives: fetch-and-increment, test-and-set and exchange. The block reads the old word, returns a value derived from it to the requester and writes the new word back. Nothing else touches the store in between.

A round-robin arbiter admits at most one port per clock. The admitted operation reads the old word and writes the new word in that same cycle, so concurrent requesters are serialized without any extra locking. A requester holds `req_valid` with its opcode, address and write data until it sees `req_ready`. Its result appears on `rsp_valid`, `rsp_rdata` and `rsp_err` exactly one cycle after that handshake. The reset input is asserted asynchronously and released through an internal two-stage synchronizer. No port is admitted until the release has passed through it.

Top module: `atomic_rmw_mem`

## Requirements
- R1: After reset every word reads as zero, and no port shows `req_ready` or `rsp_valid` while no request is pending.
- R2: A load (opcode 3'b000) returns the addressed word and leaves it unchanged.
- R3: A store (opcode 3'b001) writes the supplied data and returns the word's previous content.
- R4: Fetch-and-increment (opcode 3'b010) returns the old word and stores the old word plus one, modulo 2^32 (all ones becomes zero).
- R5: Test-and-set (opcode 3'b011) returns 1 when the old word was non-zero and 0 when it was zero, and leaves the word equal to 1.
- R6: Exchange (opcode 3'b100) stores the supplied data and returns the previous word.
- R7: Opcodes 3'b101, 3'b110 and 3'b111 raise `rsp_err` with `rsp_rdata` zero and leave the store unchanged. `rsp_err` is never high without `rsp_valid` on the same port.
- R8: At most one port sees `req_ready` in any cycle, and only a port that has `req_valid` high.
- R9: Whenever any port is valid, one port is admitted. Among the valid ports, the one admitted is the first one after the previously admitted port in cyclic index order. The first admission after reset scans from port 0.
- R10: `rsp_valid` pulses on the admitted port exactly one cycle after its handshake, and on no other port.
- R11: Fetch-and-increment requests from several ports to one word each obtain a distinct old value, and the final word equals the initial value plus the number of requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NP | Request pending, one bit per port |
| req_ready | output | NP | Request admitted this cycle, one bit per port |
| req_op | input | NP*3 | Opcode per port, port i at bits [3i+2:3i] |
| req_addr | input | NP*AW | Word address per port |
| req_wdata | input | NP*DW | Write or exchange data per port |
| rsp_valid | output | NP | Response pulse per port |
| rsp_rdata | output | NP*DW | Returned value per port, held between responses |
| rsp_err | output | NP | Invalid-opcode flag, valid with rsp_valid |

## Verification
Every opcode is first issued from a single port against words whose contents are known. Each result separates the returned old value from the stored new value, and the follow-up loads show what was written. The increment is pushed across the all-ones wrap, and test-and-set is applied to zero, to one and to a larger value. These patterns distinguish a non-zero test from a test against 1, and a correct wrap from a saturating counter. All three ports then hammer one word with fetch-and-increment at the same time. Duplicate or missing counts would expose a lost update, and the grant order under full contention shows whether rotation is true round robin or fixed priority. The illegal opcodes are followed by loads, which show that nothing was written.

// File: rtl/amem_pkg.sv
package amem_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_FINC  = 3'd2,
    OP_TAS   = 3'd3,
    OP_XCHG  = 3'd4
  } amem_op_e;
endpackage

// File: rtl/amem_rr_arb.sv
module amem_rr_arb #(
  parameter int N  = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] last_d;

  // Scan from the port after the last winner, wrapping once around.
  always_comb begin
    int cand;
    gnt_any = 1'b0;
    gnt_idx = last_q;
    for (int off = 1; off <= N; off++) begin
      cand = int'(last_q) + off;
      if (cand >= N) cand = cand - N;
      if (!gnt_any && req[cand]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(cand);
      end
    end
    gnt = gnt_any ? (N'(1) << gnt_idx) : '0;
  end

  always_comb begin
    last_d = last_q;
    if (gnt_any) last_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end
endmodule

// File: rtl/amem_rmw_alu.sv
module amem_rmw_alu
  import amem_pkg::*;
#(
  parameter int DW = 32
) (
  input  amem_op_e        op,
  input  logic [DW-1:0]   old_val,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   new_val,
  output logic            wr_en,
  output logic [DW-1:0]   rsp_val,
  output logic            err
);
  always_comb begin
    new_val = old_val;
    wr_en   = 1'b0;
    rsp_val = old_val;
    err     = 1'b0;
    case (op)
      OP_LOAD: ;
      OP_STORE: begin
        new_val = wdata;
        wr_en   = 1'b1;
      end
      OP_FINC: begin
        new_val = old_val + DW'(1);
        wr_en   = 1'b1;
      end
      OP_TAS: begin
        new_val = DW'(1);
        wr_en   = 1'b1;
        rsp_val = (old_val != '0) ? DW'(1) : '0;
      end
      OP_XCHG: begin
        new_val = wdata;
        wr_en   = 1'b1;
      end
      default: begin
        rsp_val = '0;
        err     = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/amem_word_store.sv
module amem_word_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [DW-1:0] wdata
);
  logic [DW-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we && (addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   words[g] <= '0;
      else if (hit) words[g] <= wdata;
    end
  end

  assign rdata = words[addr];
endmodule

// File: rtl/atomic_rmw_mem.sv
module atomic_rmw_mem
  import amem_pkg::*;
#(
  parameter int NP    = 3,
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    req_valid,
  output logic [NP-1:0]    req_ready,
  input  logic [NP*3-1:0]  req_op,
  input  logic [NP*AW-1:0] req_addr,
  input  logic [NP*DW-1:0] req_wdata,
  output logic [NP-1:0]    rsp_valid,
  output logic [NP*DW-1:0] rsp_rdata,
  output logic [NP-1:0]    rsp_err
);
  localparam int IW = (NP > 1) ? $clog2(NP) : 1;

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] sync_q;
  logic [1:0] sync_d;
  logic       rst_ok;

  assign sync_d = {sync_q[0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end
  assign rst_ok = sync_q[1];

  // Unpack per-port request fields.
  logic [OPW-1:0] op_arr   [NP];
  logic [AW-1:0]  addr_arr [NP];
  logic [DW-1:0]  wd_arr   [NP];

  for (genvar i = 0; i < NP; i++) begin : g_unpack
    assign op_arr[i]   = req_op[i*OPW +: OPW];
    assign addr_arr[i] = req_addr[i*AW +: AW];
    assign wd_arr[i]   = req_wdata[i*DW +: DW];
  end

  // Arbitration.
  logic [NP-1:0] req_live;
  logic [NP-1:0] gnt;
  logic [IW-1:0] gnt_idx;
  logic          gnt_any;

  assign req_live = req_valid & {NP{rst_ok}};

  amem_rr_arb #(.N(NP), .IW(IW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_ok),
    .req     (req_live),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  assign req_ready = gnt;

  // The winner's request.
  logic [OPW-1:0] sel_op;
  logic [AW-1:0]  sel_addr;
  logic [DW-1:0]  sel_wdata;

  always_comb begin
    sel_op    = op_arr[gnt_idx];
    sel_addr  = addr_arr[gnt_idx];
    sel_wdata = wd_arr[gnt_idx];
  end

  // Read, modify and write in one cycle.
  logic [DW-1:0] old_val;
  logic [DW-1:0] new_val;
  logic [DW-1:0] alu_rsp;
  logic          alu_we;
  logic          alu_err;
  logic          mem_we;

  amem_word_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .rst_n (rst_ok),
    .addr  (sel_addr),
    .rdata (old_val),
    .we    (mem_we),
    .wdata (new_val)
  );

  amem_rmw_alu #(.DW(DW)) u_alu (
    .op      (amem_op_e'(sel_op)),
    .old_val (old_val),
    .wdata   (sel_wdata),
    .new_val (new_val),
    .wr_en   (alu_we),
    .rsp_val (alu_rsp),
    .err     (alu_err)
  );

  assign mem_we = gnt_any && alu_we;

  // Response registers, one set per port.
  for (genvar i = 0; i < NP; i++) begin : g_rsp
    logic          rv_q, rv_d;
    logic          re_q, re_d;
    logic [DW-1:0] rd_q, rd_d;

    always_comb begin
      rv_d = gnt[i];
      re_d = gnt[i] && alu_err;
      rd_d = gnt[i] ? alu_rsp : rd_q;
    end

    always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok) begin
        rv_q <= 1'b0;
        re_q <= 1'b0;
        rd_q <= '0;
      end else begin
        rv_q <= rv_d;
        re_q <= re_d;
        rd_q <= rd_d;
      end
    end

    assign rsp_valid[i]          = rv_q;
    assign rsp_err[i]            = re_q;
    assign rsp_rdata[i*DW +: DW] = rd_q;
  end
endmodule

// File: rtl/amem_checker.sv
module amem_checker #(
  parameter int NP = 3
) (
  input logic          clk,
  input logic          rst_ok,
  input logic [NP-1:0] req_valid,
  input logic [NP-1:0] req_ready,
  input logic [NP-1:0] rsp_valid,
  input logic [NP-1:0] rsp_err
);
  assert_ready_onehot_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(req_ready));

  assert_ready_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_ready & ~req_valid) == '0);

  assert_work_conserving_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid != '0) |-> (req_ready != '0));

  assert_rsp_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_valid == $past(req_valid & req_ready));

  assert_err_only_with_rsp_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (rsp_err & ~rsp_valid) == '0);
endmodule

bind atomic_rmw_mem amem_checker #(.NP(NP)) u_amem_checker (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err)
);

// File: tb/test_atomic_rmw_mem.sv
`timescale 1ns/1ps
module test_atomic_rmw_mem;
  localparam int NP = 3;
  localparam int DW = 32;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic             clk;
  logic             rst_n;
  logic [NP-1:0]    req_valid;
  logic [NP-1:0]    req_ready;
  logic [NP*3-1:0]  req_op;
  logic [NP*AW-1:0] req_addr;
  logic [NP*DW-1:0] req_wdata;
  logic [NP-1:0]    rsp_valid;
  logic [NP*DW-1:0] rsp_rdata;
  logic [NP-1:0]    rsp_err;

  atomic_rmw_mem #(.NP(NP), .DW(DW), .DEPTH(DEPTH), .AW(AW)) i_atomic_rmw_mem (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic          v  [NP];
  logic [2:0]    ov [NP];
  logic [AW-1:0] av [NP];
  logic [DW-1:0] wv [NP];

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      req_valid[p]          = v[p];
      req_op[p*3 +: 3]      = ov[p];
      req_addr[p*AW +: AW]  = av[p];
      req_wdata[p*DW +: DW] = wv[p];
    end
  end

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit active = 0;
  logic [DW-1:0] model [DEPTH];

  int          q_port [$];
  logic [DW-1:0] q_data [$];
  bit          q_err  [$];
  int          q_cyc  [$];
  string       q_tag  [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: present a request, wait for admission, predict its result.
  task automatic drive(input int p, input logic [2:0] o, input logic [AW-1:0] a,
                       input logic [DW-1:0] w, input string tag);
    logic [DW-1:0] old, rd;
    bit e;
    @(negedge clk);
    v[p] = 1'b1; ov[p] = o; av[p] = a; wv[p] = w;
    #1;
    while (!req_ready[p]) begin
      @(negedge clk);
      #1;
    end
    old = model[a];
    rd = old;
    e = 1'b0;
    case (o)
      3'd0: ;
      3'd1: model[a] = w;
      3'd2: model[a] = old + 1;
      3'd3: begin rd = (old != 0) ? 1 : 0; model[a] = 1; end
      3'd4: model[a] = w;
      default: begin rd = 0; e = 1'b1; end
    endcase
    q_port.push_back(p); q_data.push_back(rd); q_err.push_back(e);
    q_cyc.push_back(cyc); q_tag.push_back(tag);
    @(posedge clk);
    #1 v[p] = 1'b0;
  endtask

  // Monitor: compare each response against the scoreboard.
  initial forever begin
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      if (rsp_valid[p]) begin
        if (q_port.size() == 0) begin
          chk(0, "R10 unexpected response", DW'(p), 0);
        end else begin
          int ep, ec;
          logic [DW-1:0] ed;
          bit ee;
          string t;
          ep = q_port.pop_front(); ed = q_data.pop_front(); ee = q_err.pop_front();
          ec = q_cyc.pop_front(); t = q_tag.pop_front();
          chk(ep == p, "R10 response port", DW'(p), DW'(ep));
          chk(cyc == ec + 1, "R10 response latency", DW'(cyc), DW'(ec + 1));
          chk(rsp_rdata[p*DW +: DW] === ed, t, rsp_rdata[p*DW +: DW], ed);
          chk(rsp_err[p] === ee, {t, " err"}, DW'(rsp_err[p]), DW'(ee));
        end
      end
    end
  end

  // Arbitration reference: one grant, only to a valid port, next after last.
  int last_g = NP - 1;
  initial forever begin
    @(negedge clk);
    #2;
    if (active) begin
      int nv, expg;
      nv = $countones(req_valid);
      if (nv > 0) begin
        chk($countones(req_ready) == 1 && (req_ready & ~req_valid) == 0,
            "R8 single admitted valid port", DW'(req_ready), DW'(req_valid));
      end
      if (nv >= 2) begin
        expg = -1;
        for (int off = 1; off <= NP; off++) begin
          int c;
          c = (last_g + off) % NP;
          if (expg < 0 && req_valid[c]) expg = c;
        end
        chk(req_ready == (NP'(1) << expg), "R9 round robin pick", DW'(req_ready), DW'(1 << expg));
      end
      for (int p = 0; p < NP; p++) if (req_ready[p]) last_g = p;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    for (int p = 0; p < NP; p++) begin v[p] = 0; ov[p] = 0; av[p] = 0; wv[p] = 0; end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 0 && rsp_valid == 0, "R1 idle after reset", DW'({req_ready, rsp_valid}), 0);
    active = 1;

    drive(0, 3'd0, 6'd0, 0, "R1 reset word 0");
    drive(1, 3'd0, 6'd63, 0, "R1 reset word 63");
    drive(2, 3'd1, 6'd5, 32'hA5A5_0001, "R3 store returns old");
    drive(0, 3'd0, 6'd5, 0, "R2 load after store");
    drive(1, 3'd0, 6'd5, 0, "R2 load leaves word");
    drive(2, 3'd1, 6'd5, 32'h0000_BEEF, "R3 store returns previous");
    drive(0, 3'd2, 6'd7, 0, "R4 fetch-inc first");
    drive(0, 3'd2, 6'd7, 0, "R4 fetch-inc second");
    drive(1, 3'd0, 6'd7, 0, "R4 incremented word");
    drive(1, 3'd1, 6'd8, 32'hFFFF_FFFF, "R3 store all ones");
    drive(2, 3'd2, 6'd8, 0, "R4 fetch-inc at all ones");
    drive(0, 3'd0, 6'd8, 0, "R4 wrapped to zero");
    drive(1, 3'd3, 6'd9, 0, "R5 test-and-set on zero");
    drive(2, 3'd3, 6'd9, 0, "R5 test-and-set on one");
    drive(0, 3'd1, 6'd9, 32'h40, "R3 store before tas");
    drive(1, 3'd3, 6'd9, 0, "R5 test-and-set on 0x40");
    drive(2, 3'd0, 6'd9, 0, "R5 word becomes one");
    drive(0, 3'd4, 6'd5, 32'h1234, "R6 exchange returns old");
    drive(1, 3'd0, 6'd5, 0, "R6 exchanged word");
    drive(2, 3'd5, 6'd5, 32'hDEAD, "R7 opcode 5");
    drive(0, 3'd6, 6'd5, 32'hDEAD, "R7 opcode 6");
    drive(1, 3'd7, 6'd5, 32'hDEAD, "R7 opcode 7");
    drive(2, 3'd0, 6'd5, 0, "R7 word unchanged");

    fork
      begin for (int k = 0; k < 4; k++) drive(0, 3'd2, 6'd20, 0, "R11 contended fetch-inc"); end
      begin for (int k = 0; k < 4; k++) drive(1, 3'd2, 6'd20, 0, "R11 contended fetch-inc"); end
      begin for (int k = 0; k < 4; k++) drive(2, 3'd2, 6'd20, 0, "R11 contended fetch-inc"); end
    join
    drive(0, 3'd0, 6'd20, 0, "R11 final count");
    chk(model[20] == 12, "R11 total increments", model[20], 12);

    fork
      begin drive(0, 3'd4, 6'd30, 32'h11, "R6 contended exchange"); drive(0, 3'd0, 6'd31, 0, "R2 contended load"); end
      begin drive(1, 3'd3, 6'd30, 0, "R5 contended tas"); drive(1, 3'd1, 6'd31, 32'h77, "R3 contended store"); end
      begin drive(2, 3'd2, 6'd30, 0, "R4 contended fetch-inc"); drive(2, 3'd7, 6'd31, 32'h9, "R7 contended bad op"); end
    join
    drive(0, 3'd0, 6'd30, 0, "R2 word 30 final");
    drive(1, 3'd0, 6'd31, 0, "R7 word 31 final");

    repeat (4) @(negedge clk);
    chk(q_port.size() == 0, "R10 all responses seen", DW'(q_port.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule